// File: doc/BRIEF.md
# Table-Driven Register Sequencer

This block runs a fixed list of register operations that is held in a small table next to it. It is typically used to bring a subsystem up or down in a set order. After a start pulse it fetches one entry per step and decides whether the entry applies to the current silicon. The decision uses the revision, fabrication process and host link that arrive on configuration pins. An entry that applies then does one of five things: a masked read, a masked read-modify-write, a poll that waits for masked bits to reach a target value, a timed wait, or the end of the list.

Register traffic goes out on a simple request/acknowledge master port. The port carries a 4-bit address-space selector, a 16-bit offset and byte-wide data. Timing comes from an internal prescaler that derives microsecond and millisecond ticks from the clock. When the list finishes, the engine raises done together with either pass or fail. It holds that verdict until the next start. A poll that runs out of attempts gives fail and halts the list.

Top module: `regseq_engine`

## Requirements
- R1: An entry is 56 bits: offset [55:40], revision mask [39:32], fab mask [31:28], link mask [27:24], space [23:20], command [19:16], bit mask [15:8], value [7:0]. The engine reads the entry selected by `tbl_idx` from `tbl_data`, starting at index 0.
- R2: An entry runs only if revision-mask bit `cfg_rev`, fab-mask bit `cfg_fab` and link-mask bit `cfg_intf` are all set. Otherwise it makes no bus access and the next entry follows. An all-ones mask matches every configuration.
- R3: Command 0 (read) makes one bus read at `bus_space`/`bus_addr` = space/offset and sets `rd_value` to the read data ANDed with the bit mask.
- R4: Command 1 (write) reads the register and then, as the very next transfer, writes to the same address the value (old AND NOT mask) OR (value AND mask).
- R5: Command 2 (poll) reads the register until (data AND mask) equals (value AND mask). The list then continues. Bits outside the mask are ignored.
- R6: A poll makes at most POLL_TRIES reads. A match on the last allowed read still counts as success. If none of them matches, the engine stops with done and fail, and no later entry runs.
- R7: Consecutive poll reads are separated by at least POLL_GAP_US microseconds and by less than that plus 16 clock cycles.
- R8: Command 3 (wait) makes no bus access. It waits for the offset field as a count, in microseconds when value bit 0 is 0 and in milliseconds when it is 1; the mask is ignored. The wait lasts at least the count and less than the count plus 16 clock cycles. A count of 0 moves on at once.
- R9: Command 4 (end) stops the list with done and pass. Codes 5 to 15 are skipped like a filtered entry. Whenever done is high, exactly one of pass and fail is high.
- R10: After reset, done, pass, fail, busy and `bus_req` are 0 and `tbl_idx` is 0. done and the verdict hold until the next start. A start while busy is ignored.
- R11: Once raised, `bus_req` stays high, and the address, space and direction stay fixed, until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the list at entry 0 |
| cfg_rev | input | 3 | Silicon revision index |
| cfg_fab | input | 1 | Fabrication process index |
| cfg_intf | input | 2 | Host link index (0 SDIO, 1 USB, 2 PCIe) |
| tbl_idx | output | IDX_W | Table entry being fetched |
| tbl_data | input | 56 | Entry contents for `tbl_idx` |
| bus_req | output | 1 | Register transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_space | output | 4 | Address-space selector |
| bus_addr | output | 16 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with ack |
| bus_ack | input | 1 | Transfer complete |
| rd_value | output | 8 | Masked result of the last read command |
| busy | output | 1 | List in progress |
| done | output | 1 | List finished |
| pass | output | 1 | Finished at an end entry |
| fail | output | 1 | Finished on poll timeout |

## Verification
The sharpest coincidence is the one between a poll's match and its timeout. Both are decided on the same acknowledge of the final permitted read. The bench model changes the polled register just before the last allowed read, and the run must then end in pass with exactly POLL_TRIES reads. A register that never matches must give fail after the same number of reads, and the write entry that follows must never run. A second start pulse that arrives while a wait is counting is also checked: the transfer log must show only one pass through the list.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    localparam int ENTRY_W = 56;
    localparam int REV_W   = 3;
    localparam int INTF_W  = 2;

    typedef struct packed {
        logic [15:0] offset;
        logic [7:0]  rev_m;
        logic [3:0]  fab_m;
        logic [3:0]  intf_m;
        logic [3:0]  space;
        logic [3:0]  cmd;
        logic [7:0]  mask;
        logic [7:0]  value;
    } entry_t;

    typedef enum logic [3:0] {
        OP_READ  = 4'd0,
        OP_WRITE = 4'd1,
        OP_POLL  = 4'd2,
        OP_WAIT  = 4'd3,
        OP_END   = 4'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_RD,
        ST_WR,
        ST_WAIT,
        ST_GAP,
        ST_FIN
    } state_e;

    function automatic logic [7:0] merge_bits(input logic [7:0] old,
                                              input logic [7:0] mask,
                                              input logic [7:0] val);
        return (old & ~mask) | (val & mask);
    endfunction

    function automatic logic masked_eq(input logic [7:0] a,
                                       input logic [7:0] b,
                                       input logic [7:0] mask);
        return (a & mask) == (b & mask);
    endfunction

endpackage

// File: rtl/regseq_tick.sv
// Microsecond and millisecond tick generator; clr restarts both phases.
module regseq_tick #(
    parameter int CLK_PER_US = 100,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic us_tick,
    output logic ms_tick
);
    localparam int CW = $clog2(CLK_PER_US + 1);
    localparam int UW = $clog2(US_PER_MS + 1);

    logic [CW-1:0] cyc;
    logic [UW-1:0] usc;

    assign us_tick = !clr && (cyc == CW'(CLK_PER_US - 1));
    assign ms_tick = us_tick && (usc == UW'(US_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cyc <= '0;
            usc <= '0;
        end else begin
            if (us_tick) begin
                cyc <= '0;
                usc <= ms_tick ? '0 : usc + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/regseq_waitcnt.sv
// Countdown in microsecond or millisecond units; pulses expired on the last tick.
module regseq_waitcnt (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] load_val,
    input  logic        load_ms,
    input  logic        us_tick,
    input  logic        ms_tick,
    output logic        expired
);
    logic [15:0] cnt;
    logic        run;
    logic        use_ms;
    logic        tick;

    assign tick    = use_ms ? ms_tick : us_tick;
    assign expired = run && tick && (cnt == 16'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            run    <= 1'b0;
            use_ms <= 1'b0;
        end else if (load) begin
            cnt    <= load_val;
            run    <= (load_val != 16'd0);
            use_ms <= load_ms;
        end else if (run && tick) begin
            cnt <= cnt - 1'b1;
            if (cnt == 16'd1) run <= 1'b0;
        end
    end
endmodule

// File: rtl/regseq_filter.sv
// Decides whether an entry applies to the present silicon configuration.
module regseq_filter
    import regseq_pkg::*;
(
    input  logic [7:0]        rev_m,
    input  logic [3:0]        fab_m,
    input  logic [3:0]        intf_m,
    input  logic [REV_W-1:0]  cfg_rev,
    input  logic              cfg_fab,
    input  logic [INTF_W-1:0] cfg_intf,
    output logic              hit
);
    always_comb begin
        hit = rev_m[cfg_rev] && fab_m[{1'b0, cfg_fab}] && intf_m[cfg_intf];
    end
endmodule

// File: rtl/regseq_ctrl.sv
// Fetch / decode / execute sequencer.
module regseq_ctrl
    import regseq_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int POLL_TRIES  = 5000,
    parameter int POLL_GAP_US = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  entry_t           fetched,
    input  logic             hit,
    input  logic             expired,
    input  logic [7:0]       rdata,
    input  logic             ack,
    output entry_t           ent,
    output logic [IDX_W-1:0] idx,
    output logic             wait_load,
    output logic [15:0]      wait_val,
    output logic             wait_ms,
    output logic             req,
    output logic             we,
    output logic [3:0]       space,
    output logic [15:0]      addr,
    output logic [7:0]       wdata,
    output logic [7:0]       rd_value,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fail
);
    localparam int TW = $clog2(POLL_TRIES + 1);

    state_e        state;
    logic [TW-1:0] tries;
    logic          poll_hit;
    logic          last_try;
    logic          is_op;

    assign poll_hit = masked_eq(rdata, ent.value, ent.mask);
    assign last_try = (tries == TW'(POLL_TRIES - 1));
    assign is_op    = (ent.cmd == OP_READ) || (ent.cmd == OP_WRITE) || (ent.cmd == OP_POLL);

    always_comb begin
        wait_load = 1'b0;
        wait_val  = 16'(POLL_GAP_US);
        wait_ms   = 1'b0;
        if (state == ST_DECODE) begin
            wait_val  = ent.offset;
            wait_ms   = ent.value[0];
            wait_load = hit && (ent.cmd == OP_WAIT) && (ent.offset != 16'd0);
        end else if (state == ST_RD) begin
            wait_load = ack && (ent.cmd == OP_POLL) && !poll_hit && !last_try;
        end
    end

    assign req   = (state == ST_RD) || (state == ST_WR);
    assign we    = (state == ST_WR);
    assign space = ent.space;
    assign addr  = ent.offset;
    assign busy  = (state != ST_IDLE) && (state != ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            ent      <= '0;
            tries    <= '0;
            wdata    <= '0;
            rd_value <= '0;
            done     <= 1'b0;
            pass     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        idx   <= '0;
                        done  <= 1'b0;
                        pass  <= 1'b0;
                        fail  <= 1'b0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ent   <= fetched;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (!hit) begin
                        idx   <= idx + 1'b1;
                        state <= ST_FETCH;
                    end else if (is_op) begin
                        tries <= '0;
                        state <= ST_RD;
                    end else if (ent.cmd == OP_WAIT) begin
                        if (ent.offset == 16'd0) begin
                            idx   <= idx + 1'b1;
                            state <= ST_FETCH;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else if (ent.cmd == OP_END) begin
                        done  <= 1'b1;
                        pass  <= 1'b1;
                        state <= ST_FIN;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_RD: begin
                    if (ack) begin
                        if (ent.cmd == OP_READ) begin
                            rd_value <= rdata & ent.mask;
                            idx      <= idx + 1'b1;
                            state    <= ST_FETCH;
                        end else if (ent.cmd == OP_WRITE) begin
                            wdata <= merge_bits(rdata, ent.mask, ent.value);
                            state <= ST_WR;
                        end else if (poll_hit) begin
                            idx   <= idx + 1'b1;
                            state <= ST_FETCH;
                        end else if (last_try) begin
                            done  <= 1'b1;
                            fail  <= 1'b1;
                            state <= ST_FIN;
                        end else begin
                            tries <= tries + 1'b1;
                            state <= ST_GAP;
                        end
                    end
                end
                ST_WR: begin
                    if (ack) begin
                        idx   <= idx + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_WAIT: begin
                    if (expired) begin
                        idx   <= idx + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_GAP: begin
                    if (expired) state <= ST_RD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
    import regseq_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int CLK_PER_US  = 100,
    parameter int US_PER_MS   = 1000,
    parameter int POLL_TRIES  = 5000,
    parameter int POLL_GAP_US = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [REV_W-1:0]   cfg_rev,
    input  logic               cfg_fab,
    input  logic [INTF_W-1:0]  cfg_intf,
    output logic [IDX_W-1:0]   tbl_idx,
    input  logic [ENTRY_W-1:0] tbl_data,
    output logic               bus_req,
    output logic               bus_we,
    output logic [3:0]         bus_space,
    output logic [15:0]        bus_addr,
    output logic [7:0]         bus_wdata,
    input  logic [7:0]         bus_rdata,
    input  logic               bus_ack,
    output logic [7:0]         rd_value,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic               fail
);
    entry_t      fetched;
    entry_t      ent;
    logic        hit;
    logic        us_tick;
    logic        ms_tick;
    logic        expired;
    logic        wait_load;
    logic [15:0] wait_val;
    logic        wait_ms;

    assign fetched = entry_t'(tbl_data);

    regseq_tick #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
        .clk(clk), .rst(rst), .clr(wait_load),
        .us_tick(us_tick), .ms_tick(ms_tick)
    );

    regseq_waitcnt u_wait (
        .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val),
        .load_ms(wait_ms), .us_tick(us_tick), .ms_tick(ms_tick),
        .expired(expired)
    );

    regseq_filter u_filt (
        .rev_m(ent.rev_m), .fab_m(ent.fab_m), .intf_m(ent.intf_m),
        .cfg_rev(cfg_rev), .cfg_fab(cfg_fab), .cfg_intf(cfg_intf),
        .hit(hit)
    );

    regseq_ctrl #(.IDX_W(IDX_W), .POLL_TRIES(POLL_TRIES), .POLL_GAP_US(POLL_GAP_US)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .fetched(fetched), .hit(hit),
        .expired(expired), .rdata(bus_rdata), .ack(bus_ack), .ent(ent),
        .idx(tbl_idx), .wait_load(wait_load), .wait_val(wait_val), .wait_ms(wait_ms),
        .req(bus_req), .we(bus_we), .space(bus_space), .addr(bus_addr),
        .wdata(bus_wdata), .rd_value(rd_value), .busy(busy), .done(done),
        .pass(pass), .fail(fail)
    );
endmodule

// File: rtl/regseq_checker.sv
module regseq_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        bus_req,
    input logic        bus_we,
    input logic [3:0]  bus_space,
    input logic [15:0] bus_addr,
    input logic        bus_ack,
    input logic        busy,
    input logic        done,
    input logic        pass,
    input logic        fail
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_space) && $stable(bus_we));

    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass != fail));

    assert_quiet_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req && !busy);

    assert_hold_done_R10: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !done && !bus_req && !pass && !fail);

    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_we) |-> $past(bus_req && !bus_we && bus_ack));
endmodule

bind regseq_engine regseq_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .bus_req(bus_req), .bus_we(bus_we),
    .bus_space(bus_space), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .busy(busy), .done(done), .pass(pass), .fail(fail)
);

// File: tb/sim_regseq_engine.sv
module sim_regseq_engine;
    localparam int PERIOD = 10;
    localparam int CPU    = 4;
    localparam int TRIES  = 4;
    localparam int GAP    = 2;
    localparam int IW     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] cfg_rev = 3'd2;
    logic cfg_fab = 1'b1;
    logic [1:0] cfg_intf = 2'd1;
    logic [IW-1:0] tbl_idx;
    logic [55:0] tbl_data;
    logic bus_req, bus_we, bus_ack;
    logic [3:0] bus_space;
    logic [15:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, rd_value;
    logic busy, done, pass, fail;

    logic [55:0] tbl [0:15];
    logic [7:0]  mem [0:1023];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int lg_n = 0;
    logic lg_we [0:63];
    int lg_idx [0:63];
    logic [7:0] lg_dat [0:63];
    int lg_cyc [0:63];
    int flip_idx = -1;
    int flip_k = 0;
    int rd_cnt = 0;
    logic [7:0] flip_val = 8'h00;

    always #(PERIOD/2) clk = ~clk;

    assign tbl_data  = tbl[tbl_idx];
    assign bus_rdata = mem[{bus_space[1:0], bus_addr[7:0]}];

    regseq_engine #(.IDX_W(IW), .CLK_PER_US(CPU), .POLL_TRIES(TRIES), .POLL_GAP_US(GAP)) u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_rev(cfg_rev), .cfg_fab(cfg_fab),
        .cfg_intf(cfg_intf), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .rd_value(rd_value), .busy(busy), .done(done), .pass(pass), .fail(fail)
    );

    // Register model: one-cycle acknowledge, transfer log, optional value change for polls.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) bus_ack <= 1'b0;
        else     bus_ack <= bus_req && !bus_ack;
        if (bus_req && bus_ack) begin
            if (lg_n < 64) begin
                lg_we[lg_n]  <= bus_we;
                lg_idx[lg_n] <= int'({bus_space[1:0], bus_addr[7:0]});
                lg_dat[lg_n] <= bus_we ? bus_wdata : bus_rdata;
                lg_cyc[lg_n] <= cyc;
            end
            lg_n <= lg_n + 1;
            if (bus_we) mem[{bus_space[1:0], bus_addr[7:0]}] <= bus_wdata;
            else if (int'({bus_space[1:0], bus_addr[7:0]}) == flip_idx) begin
                rd_cnt <= rd_cnt + 1;
                if (rd_cnt + 1 == flip_k - 1) mem[flip_idx] <= flip_val;
            end
        end
    end

    function automatic logic [55:0] mk(input logic [15:0] off, input logic [7:0] rv,
                                       input logic [3:0] fb, input logic [3:0] lk,
                                       input logic [3:0] sp, input logic [3:0] op,
                                       input logic [7:0] mk_m, input logic [7:0] val);
        return {off, rv, fb, lk, sp, op, mk_m, val};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic clear_tbl();
        for (int i = 0; i < 16; i++) tbl[i] = mk(16'h0, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd4, 8'h0, 8'h0);
        flip_idx = -1;
        flip_k = 0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_seq();
        int n = 0;
        lg_n = 0;
        rd_cnt = 0;
        pulse_start();
        while (!done && n < 20000) begin
            @(posedge clk); #1;
            n++;
        end
        chk("R9 finished", int'(done), 1);
    endtask

    task automatic t_reset();
        chk("R10 done after reset", int'(done), 0);
        chk("R10 req after reset", int'(bus_req), 0);
        chk("R10 verdict after reset", int'(pass | fail | busy), 0);
        chk("R10 idx after reset", int'(tbl_idx), 0);
    endtask

    task automatic t_read();
        clear_tbl();
        mem[10'h320] = 8'hA5;
        tbl[0] = mk(16'h0020, 8'hFF, 4'hF, 4'hF, 4'h3, 4'd0, 8'h0F, 8'h00);
        run_seq();
        chk("R3 one transfer", lg_n, 1);
        chk("R1 R3 address and space", lg_idx[0], 32'h320);
        chk("R3 direction read", int'(lg_we[0]), 0);
        chk("R3 masked value", int'(rd_value), 8'h05);
        chk("R9 pass at end", int'(pass), 1);
    endtask

    task automatic t_filter();
        clear_tbl();
        tbl[0] = mk(16'h0030, 8'hFB, 4'hF, 4'hF, 4'h0, 4'd0, 8'hFF, 8'h00);
        tbl[1] = mk(16'h0030, 8'hFF, 4'h1, 4'hF, 4'h0, 4'd0, 8'hFF, 8'h00);
        tbl[2] = mk(16'h0030, 8'hFF, 4'hF, 4'h5, 4'h0, 4'd0, 8'hFF, 8'h00);
        tbl[3] = mk(16'h0031, 8'h04, 4'h2, 4'h2, 4'h0, 4'd0, 8'hFF, 8'h00);
        tbl[4] = mk(16'h0032, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd0, 8'hFF, 8'h00);
        run_seq();
        chk("R2 only matching entries run", lg_n, 2);
        chk("R2 exact-bit entry", lg_idx[0], 32'h031);
        chk("R2 all-ones entry", lg_idx[1], 32'h032);
    endtask

    task automatic t_write();
        clear_tbl();
        mem[10'h040] = 8'hA5;
        tbl[0] = mk(16'h0040, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hF0, 8'h3C);
        run_seq();
        chk("R4 read then write", lg_n, 2);
        chk("R4 write direction", int'(lg_we[1]), 1);
        chk("R4 merged data", int'(lg_dat[1]), 8'h35);
        chk("R4 register result", int'(mem[10'h040]), 8'h35);
    endtask

    task automatic t_poll(input int k, input string tag);
        clear_tbl();
        mem[10'h050] = 8'h00;
        flip_idx = 10'h050;
        flip_k = k;
        flip_val = 8'h93;
        tbl[0] = mk(16'h0050, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd2, 8'h81, 8'hFF);
        run_seq();
        chk({tag, " reads until match"}, lg_n, k);
        chk({tag, " pass"}, int'(pass), 1);
        if (k >= 2) chk_rng("R7 poll interval", lg_cyc[1] - lg_cyc[0], GAP*CPU, GAP*CPU + 16);
    endtask

    task automatic t_timeout();
        clear_tbl();
        mem[10'h050] = 8'h00;
        tbl[0] = mk(16'h0050, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd2, 8'h81, 8'hFF);
        tbl[1] = mk(16'h0060, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h77);
        run_seq();
        chk("R6 reads before timeout", lg_n, TRIES);
        chk("R6 fail", int'(fail), 1);
        chk("R6 no pass", int'(pass), 0);
    endtask

    task automatic t_wait(input logic [15:0] cnt, input logic unit, input int lo, input int hi, input string tag);
        clear_tbl();
        tbl[0] = mk(16'h0070, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h11);
        tbl[1] = mk(cnt,      8'hFF, 4'hF, 4'hF, 4'h0, 4'd3, 8'hFF, {7'd0, unit});
        tbl[2] = mk(16'h0071, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h22);
        run_seq();
        chk({tag, " no bus access in wait"}, lg_n, 4);
        chk_rng({tag, " duration"}, lg_cyc[2] - lg_cyc[1], lo, hi);
    endtask

    task automatic t_unknown();
        clear_tbl();
        tbl[0] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd7, 8'hFF, 8'h00);
        run_seq();
        chk("R9 unknown code skipped", lg_n, 0);
        chk("R9 pass after skip", int'(pass), 1);
    endtask

    task automatic t_start_busy();
        int n = 0;
        clear_tbl();
        tbl[0] = mk(16'h0070, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h11);
        tbl[1] = mk(16'd20,   8'hFF, 4'hF, 4'hF, 4'h0, 4'd3, 8'h00, 8'h00);
        tbl[2] = mk(16'h0071, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h22);
        lg_n = 0;
        pulse_start();
        repeat (20) @(posedge clk);
        #1;
        chk("R10 busy during wait", int'(busy), 1);
        pulse_start();
        while (!done && n < 20000) begin
            @(posedge clk); #1;
            n++;
        end
        chk("R10 start while busy ignored", lg_n, 4);
        repeat (20) @(posedge clk);
        #1;
        chk("R10 done held", int'(done & pass), 1);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        clear_tbl();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_read();
        t_filter();
        t_write();
        t_poll(2, "R5");
        t_poll(TRIES, "R6 last attempt");
        t_timeout();
        t_wait(16'd3, 1'b0, 3*CPU, 3*CPU + 16, "R8 us");
        t_wait(16'd2, 1'b1, 2000*CPU, 2000*CPU + 16, "R8 ms");
        t_wait(16'd0, 1'b0, 0, 8, "R8 zero");
        t_unknown();
        t_start_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule